// File: doc/BRIEF.md
# Memory Bring-Up Retry Sequencer

This block brings an external memory interface up in a fixed order and repeats that whole order whenever the memory fails its check. Once `start` is seen, it asks an outside agent to initialise the clock PLL and waits for that agent to finish. It then holds off for a settling time measured in clock cycles. Next it asks a second agent to initialise the memory PHY and controller. It then waits for both that agent's completion and a second, longer settling period, which is counted from the request. Last, it asks a test engine to check a fixed address window.

When the test passes, `ready` rises and stays high. When the test fails, the sequence starts again from the PLL step, never from a middle step, and the attempt number goes up by one. If the final permitted attempt fails, the block stops and raises `give_up`.

Each settling time is derived from a clock-frequency parameter (`CLK_MHZ`) and a duration in microseconds. The defaults are 600 µs after PLL completion and 3000 µs after the memory request. The current attempt number is always visible on `attempt`.

Top module: `mem_init_seq`

## Requirements
- R1: While `rst_n` is low, and after reset until `start` is sampled high in the idle state, all request outputs, `ready` and `give_up` are 0 and `attempt` is 0. Sampling `start` high in idle sets `attempt` to 1 and raises `pll_start` on the following cycle.
- R2: `pll_start`, `mem_start` and `test_start` are each high for exactly one cycle per step, and at most one of them is high in any cycle.
- R3: With WA = `CLK_MHZ`·`WAIT_A_US`, `mem_start` goes high exactly WA+2 cycles after the cycle in which an accepted `pll_done` was high.
- R4: With WB = `CLK_MHZ`·`WAIT_B_US`, `mem_start` high in cycle m and the first accepted `mem_done` in cycle d, `test_start` goes high in cycle max(m+WB+1, d+1).
- R5: A done input (`pll_done`, `mem_done`, `test_done`) counts only from the cycle after its request pulse until the step ends. A done that is high during the request cycle or in any other step is ignored.
- R6: A `test_done` with `test_fail`=0 makes `ready` go high on the next cycle. `ready` then stays high until reset, and `start` has no further effect.
- R7: A `test_done` with `test_fail`=1 while `attempt` < `MAX_ATTEMPTS` increments `attempt` and raises `pll_start` on the next cycle. `attempt` changes only in a cycle in which `pll_start` is high.
- R8: A `test_done` with `test_fail`=1 while `attempt` = `MAX_ATTEMPTS` (default 10) raises `give_up` on the next cycle. `give_up` stays high until reset, `attempt` stays at `MAX_ATTEMPTS`, and no further request is issued.
- R9: `test_base` constantly equals `TEST_BASE` (default 0x8000_0000) and `test_bytes` constantly equals `TEST_KB`·1024 (default 131072).
- R10: Pulling `rst_n` low returns every output to its R1 value at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin the bring-up (used in idle only) |
| pll_start | output | 1 | One-cycle request to the PLL agent |
| pll_done | input | 1 | PLL agent finished |
| mem_start | output | 1 | One-cycle request to the PHY/controller agent |
| mem_done | input | 1 | PHY/controller agent finished |
| test_start | output | 1 | One-cycle request to the test engine |
| test_done | input | 1 | Test engine finished |
| test_fail | input | 1 | Qualifies `test_done`: 1 = mismatch found |
| test_base | output | ADDR_W | First byte address of the test window |
| test_bytes | output | ADDR_W | Size of the test window in bytes |
| ready | output | 1 | Memory passed its test (sticky) |
| give_up | output | 1 | All attempts failed (sticky) |
| attempt | output | $clog2(MAX_ATTEMPTS+1) | Current attempt number, 0 when idle |

## Verification
A request pulse follows the sampled `start` or the sampled test failure by one cycle. `ready` and `give_up` follow the sampled `test_done` by one cycle. `mem_start` follows the accepted `pll_done` cycle by WA+2 cycles. `test_start` falls in cycle max(m+WB+1, d+1).

The bench predicts these cycles by keeping absolute cycle numbers for each due event and compares every output on every falling edge, after the register updates have settled. Stale done pulses are injected during the request cycles, and in one run `mem_done` arrives long after the second wait has expired, so both branches of R4 occur. The asynchronous reset is checked one nanosecond after it is applied, before any clock edge.

// File: rtl/mis_pkg.sv
`timescale 1ns/1ps
package mis_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PLL_REQ,
    ST_PLL_BUSY,
    ST_SETTLE,
    ST_MEM_REQ,
    ST_MEM_BUSY,
    ST_TEST_REQ,
    ST_TEST_BUSY,
    ST_READY,
    ST_GIVEUP
  } seq_state_e;

  // cycles in a wait of 'us' microseconds at 'mhz' MHz
  function automatic int unsigned us_to_cycles(int unsigned mhz, int unsigned us);
    return mhz * us;
  endfunction

  function automatic int unsigned max_u(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // bytes in a window of 'kb' kibibytes
  function automatic int unsigned kb_to_bytes(int unsigned kb);
    return kb * 1024;
  endfunction

endpackage

// File: rtl/mis_wait_timer.sv
`timescale 1ns/1ps
module mis_wait_timer #(
  parameter int unsigned TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= len;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/mis_attempt_ctr.sv
`timescale 1ns/1ps
module mis_attempt_ctr #(
  parameter int unsigned MAX_ATTEMPTS = 10,
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          first,
  input  logic          bump,
  output logic [CW-1:0] value,
  output logic          at_max
);
  localparam logic [CW-1:0] CAP = CW'(MAX_ATTEMPTS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    value <= '0;
    else if (first)                value <= CW'(1);
    else if (bump && value < CAP)  value <= value + 1'b1;
  end

  assign at_max = (value == CAP);
endmodule

// File: rtl/mis_seq_ctrl.sv
`timescale 1ns/1ps
module mis_seq_ctrl
  import mis_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       pll_done,
  input  logic       mem_done,
  input  logic       test_done,
  input  logic       test_fail,
  input  logic       tmr_expired,
  input  logic       at_max,
  output seq_state_e state,
  output logic       tmr_load,
  output logic       tmr_sel_b,
  output logic       cnt_first,
  output logic       cnt_bump,
  output logic       ev_pll_acc,
  output logic       ev_pass,
  output logic       ev_giveup
);
  seq_state_e nxt;
  logic       mem_seen_q, mem_seen_d;

  always_comb begin
    nxt        = state;
    mem_seen_d = mem_seen_q;
    tmr_load   = 1'b0;
    tmr_sel_b  = 1'b0;
    cnt_first  = 1'b0;
    cnt_bump   = 1'b0;
    ev_pll_acc = 1'b0;
    ev_pass    = 1'b0;
    ev_giveup  = 1'b0;
    case (state)
      ST_IDLE: if (start) begin
        nxt       = ST_PLL_REQ;
        cnt_first = 1'b1;
      end
      ST_PLL_REQ:  nxt = ST_PLL_BUSY;
      ST_PLL_BUSY: if (pll_done) begin
        nxt        = ST_SETTLE;
        tmr_load   = 1'b1;
        ev_pll_acc = 1'b1;
      end
      ST_SETTLE: if (tmr_expired) begin
        nxt       = ST_MEM_REQ;
        tmr_load  = 1'b1;
        tmr_sel_b = 1'b1;
      end
      ST_MEM_REQ: begin
        nxt        = ST_MEM_BUSY;
        mem_seen_d = 1'b0;
      end
      ST_MEM_BUSY: begin
        if (mem_done) mem_seen_d = 1'b1;
        if ((mem_seen_q || mem_done) && tmr_expired) nxt = ST_TEST_REQ;
      end
      ST_TEST_REQ:  nxt = ST_TEST_BUSY;
      ST_TEST_BUSY: if (test_done) begin
        if (!test_fail) begin
          nxt     = ST_READY;
          ev_pass = 1'b1;
        end else if (at_max) begin
          nxt       = ST_GIVEUP;
          ev_giveup = 1'b1;
        end else begin
          nxt      = ST_PLL_REQ;
          cnt_bump = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      mem_seen_q <= 1'b0;
    end else begin
      state      <= nxt;
      mem_seen_q <= mem_seen_d;
    end
  end
endmodule

// File: rtl/mem_init_seq.sv
`timescale 1ns/1ps
module mem_init_seq
  import mis_pkg::*;
#(
  parameter int unsigned CLK_MHZ      = 200,
  parameter int unsigned WAIT_A_US    = 600,
  parameter int unsigned WAIT_B_US    = 3000,
  parameter int unsigned MAX_ATTEMPTS = 10,
  parameter int unsigned ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] TEST_BASE = 'h8000_0000,
  parameter int unsigned TEST_KB      = 128,
  localparam int unsigned CW          = $clog2(MAX_ATTEMPTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              pll_start,
  input  logic              pll_done,
  output logic              mem_start,
  input  logic              mem_done,
  output logic              test_start,
  input  logic              test_done,
  input  logic              test_fail,
  output logic [ADDR_W-1:0] test_base,
  output logic [ADDR_W-1:0] test_bytes,
  output logic              ready,
  output logic              give_up,
  output logic [CW-1:0]     attempt
);
  localparam int unsigned WA_CYC = us_to_cycles(CLK_MHZ, WAIT_A_US);
  localparam int unsigned WB_CYC = us_to_cycles(CLK_MHZ, WAIT_B_US);
  localparam int unsigned TW     = $clog2(max_u(WA_CYC, WB_CYC) + 1);

  seq_state_e    state;
  logic          tmr_load, tmr_sel_b, tmr_expired;
  logic          cnt_first, cnt_bump, at_max;
  logic          ev_pll_acc, ev_pass, ev_giveup;
  logic [TW-1:0] tmr_len;

  mis_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .pll_done   (pll_done),
    .mem_done   (mem_done),
    .test_done  (test_done),
    .test_fail  (test_fail),
    .tmr_expired(tmr_expired),
    .at_max     (at_max),
    .state      (state),
    .tmr_load   (tmr_load),
    .tmr_sel_b  (tmr_sel_b),
    .cnt_first  (cnt_first),
    .cnt_bump   (cnt_bump),
    .ev_pll_acc (ev_pll_acc),
    .ev_pass    (ev_pass),
    .ev_giveup  (ev_giveup)
  );

  assign tmr_len = tmr_sel_b ? TW'(WB_CYC) : TW'(WA_CYC);

  mis_wait_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (tmr_load),
    .len    (tmr_len),
    .expired(tmr_expired)
  );

  mis_attempt_ctr #(.MAX_ATTEMPTS(MAX_ATTEMPTS), .CW(CW)) u_attempts (
    .clk   (clk),
    .rst_n (rst_n),
    .first (cnt_first),
    .bump  (cnt_bump),
    .value (attempt),
    .at_max(at_max)
  );

  assign pll_start  = (state == ST_PLL_REQ);
  assign mem_start  = (state == ST_MEM_REQ);
  assign test_start = (state == ST_TEST_REQ);
  assign ready      = (state == ST_READY);
  assign give_up    = (state == ST_GIVEUP);
  assign test_base  = TEST_BASE;
  assign test_bytes = ADDR_W'(kb_to_bytes(TEST_KB));
endmodule

// File: rtl/mis_checker.sv
`timescale 1ns/1ps
module mis_checker #(
  parameter int unsigned WA_CYC       = 1,
  parameter int unsigned WB_CYC       = 1,
  parameter int unsigned MAX_ATTEMPTS = 10,
  parameter int unsigned CW           = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pll_start,
  input logic          mem_start,
  input logic          test_start,
  input logic          pll_acc,
  input logic          pass_evt,
  input logic          giveup_evt,
  input logic          test_done,
  input logic          test_fail,
  input logic          ready,
  input logic          give_up,
  input logic [CW-1:0] attempt
);
  localparam int unsigned LIM = WA_CYC + WB_CYC + 8;
  int unsigned since_pll, since_mem;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      since_pll <= 0;
      since_mem <= 0;
    end else begin
      if (pll_acc)               since_pll <= 0;
      else if (since_pll < LIM)  since_pll <= since_pll + 1;
      if (mem_start)             since_mem <= 0;
      else if (since_mem < LIM)  since_mem <= since_mem + 1;
    end
  end

  p_one_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pll_start, mem_start, test_start}));
  p_req_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_start || mem_start || test_start) |=> !(pll_start || mem_start || test_start));
  p_settle_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_start |-> (since_pll == WA_CYC + 1));
  p_settle_b_r4: assert property (@(posedge clk) disable iff (!rst_n)
    test_start |-> (since_mem >= WB_CYC));
  p_ready_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> ready);
  p_ready_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(pass_evt && test_done && !test_fail));
  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && give_up));
  p_retry_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (attempt != $past(attempt)) |-> pll_start);
  p_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    attempt <= CW'(MAX_ATTEMPTS));
  p_giveup_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    give_up |=> give_up);
  p_giveup_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(give_up) |-> ($past(giveup_evt && test_fail) && attempt == CW'(MAX_ATTEMPTS)));
endmodule

bind mem_init_seq mis_checker #(
  .WA_CYC(WA_CYC), .WB_CYC(WB_CYC), .MAX_ATTEMPTS(MAX_ATTEMPTS), .CW(CW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pll_start (pll_start),
  .mem_start (mem_start),
  .test_start(test_start),
  .pll_acc   (ev_pll_acc),
  .pass_evt  (ev_pass),
  .giveup_evt(ev_giveup),
  .test_done (test_done),
  .test_fail (test_fail),
  .ready     (ready),
  .give_up   (give_up),
  .attempt   (attempt)
);

// File: tb/tb_mem_init_seq.sv
`timescale 1ns/1ps
module tb_mem_init_seq;
  localparam int MHZ  = 1;
  localparam int WA   = 600;
  localparam int WB   = 3000;
  localparam int MAXA = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic pll_done = 1'b0, mem_done = 1'b0, test_done = 1'b0, test_fail = 1'b0;
  logic pll_start, mem_start, test_start, ready, give_up;
  logic [31:0] test_base, test_bytes;
  logic [3:0]  attempt;

  mem_init_seq #(.CLK_MHZ(MHZ), .WAIT_A_US(600), .WAIT_B_US(3000), .MAX_ATTEMPTS(MAXA)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .pll_start(pll_start), .pll_done(pll_done),
    .mem_start(mem_start), .mem_done(mem_done),
    .test_start(test_start), .test_done(test_done), .test_fail(test_fail),
    .test_base(test_base), .test_bytes(test_bytes),
    .ready(ready), .give_up(give_up), .attempt(attempt)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // ---------------- reference model: phases plus absolute due cycles
  localparam int P_IDLE = 0, P_PREQ = 1, P_PBUSY = 2, P_WAITA = 3, P_MREQ = 4,
                 P_MBUSY = 5, P_TREQ = 6, P_TBUSY = 7, P_DONE = 8, P_GIVE = 9;
  int ph = P_IDLE, m_att = 0, cyc = 0, mem_due = 0, test_due = 0;
  bit m_seen = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph = P_IDLE; m_att = 0; m_seen = 0;
    end else begin
      cyc++;
      case (ph)
        P_IDLE:  if (start) begin ph = P_PREQ; m_att = 1; end
        P_PREQ:  ph = P_PBUSY;
        P_PBUSY: if (pll_done) begin ph = P_WAITA; mem_due = cyc + WA + 1; end
        P_WAITA: if (cyc == mem_due) begin ph = P_MREQ; test_due = cyc + WB + 1; end
        P_MREQ:  begin ph = P_MBUSY; m_seen = 0; end
        P_MBUSY: begin
          if (mem_done) m_seen = 1;
          if (m_seen && cyc >= test_due) ph = P_TREQ;
        end
        P_TREQ:  ph = P_TBUSY;
        P_TBUSY: if (test_done) begin
          if (!test_fail) ph = P_DONE;
          else if (m_att == MAXA) ph = P_GIVE;
          else begin m_att++; ph = P_PREQ; end
        end
        default: ;
      endcase
    end
  end

  // ---------------- per-cycle compare, then agent responses
  int pass_at = 1, pll_lat = 5, mem_lat = 20, test_lat = 40;
  bit stale = 0;
  int pll_t = 0, mem_t = 0, test_t = 0;

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R2 pll_start",  pll_start,  ph == P_PREQ);
      chk("R3 mem_start",  mem_start,  ph == P_MREQ);
      chk("R4 test_start", test_start, ph == P_TREQ);
      chk("R6 ready",      ready,      ph == P_DONE);
      chk("R8 give_up",    give_up,    ph == P_GIVE);
      chk("R7 attempt",    attempt,    m_att);
    end
    if (!rst_n) begin
      pll_t = 0; mem_t = 0; test_t = 0;
      pll_done <= 0; mem_done <= 0; test_done <= 0; test_fail <= 0;
    end else begin
      if (pll_start) begin pll_t = pll_lat; pll_done <= stale; end
      else if (pll_t > 0) begin pll_t--; pll_done <= (pll_t == 0); end
      else pll_done <= 0;

      if (mem_start) begin mem_t = mem_lat; mem_done <= stale; end
      else if (mem_t > 0) begin mem_t--; mem_done <= (mem_t == 0); end
      else mem_done <= 0;

      if (test_start) begin
        test_t = test_lat; test_done <= stale; test_fail <= 0;   // stale "pass"
      end else if (test_t > 0) begin
        test_t--;
        test_done <= (test_t == 0);
        test_fail <= (test_t == 0) && (m_att < pass_at);
      end else begin
        test_done <= 0; test_fail <= 0;
      end
    end
  end

  task automatic pulse_start();
    start = 1; @(negedge clk); start = 0;
  endtask

  task automatic wait_end(int lim);
    for (int n = 0; n < lim && !(ready || give_up); n++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    wrap_up();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset pll_start", pll_start, 0);
    chk("R1 reset ready", ready, 0);
    chk("R1 reset give_up", give_up, 0);
    chk("R1 reset attempt", attempt, 0);
    chk("R9 test_base", test_base, 64'h8000_0000);
    chk("R9 test_bytes", test_bytes, 131072);
    rst_n = 1;
    repeat (10) @(negedge clk);
    chk("R1 idle without start", attempt, 0);

    // pass on the first attempt, then a late start is ignored
    pulse_start();
    chk("R1 pll_start after start", pll_start, 1);
    wait_end(20000);
    chk("R6 pass on first attempt", ready, 1);
    chk("R6 attempt at pass", attempt, 1);
    pulse_start();
    repeat (10) @(negedge clk);
    chk("R6 ready held, start ignored", ready, 1);

    // stale dones and a late mem_done; pass on the fourth attempt
    do_reset();
    stale = 1; pass_at = 4; mem_lat = 3200;
    pulse_start();
    wait_end(40000);
    chk("R5 stale done ignored, attempt at pass", attempt, 4);
    chk("R7 retries then ready", ready, 1);

    // every attempt fails
    do_reset();
    stale = 0; pass_at = 99; mem_lat = 20;
    pulse_start();
    wait_end(60000);
    chk("R8 give_up raised", give_up, 1);
    chk("R8 attempt capped", attempt, MAXA);
    pulse_start();
    repeat (20) @(negedge clk);
    chk("R8 no request after give_up", pll_start, 0);
    chk("R8 give_up held", give_up, 1);

    // asynchronous reset in the middle of the first wait
    do_reset();
    pass_at = 1;
    pulse_start();
    repeat (300) @(negedge clk);
    chk("R10 attempt before reset", attempt, 1);
    #1 rst_n = 0;
    #1;
    chk("R10 attempt cleared at once", attempt, 0);
    chk("R10 requests low", {pll_start, mem_start, test_start}, 0);
    @(negedge clk); rst_n = 1;
    repeat (5) @(negedge clk);
    chk("R1 idle after reset", attempt, 0);
    wrap_up();
  end
endmodule